// File: doc/BRIEF.md
# Two-Queue Weighted Round-Robin Scheduler

This block decides which of two egress queues, an urgent one and a bulk one, sends the next frame on a single output port. Each queue raises a ready flag while it holds at least one frame. When the port is idle and at least one flag is up, the scheduler raises a one-cycle grant for exactly one queue. It then stays busy until the transmit side pulses `frame_done`. After that it can make the next decision.

Service is counted in whole frames. A stored 2-bit ratio code picks how many urgent frames may be sent before a waiting bulk frame must get its turn: 4, 8 or 16. A fourth code gives the urgent queue absolute precedence. The scheduler is work-conserving: a queue that is the only one with a frame is served at once, whatever the ratio. The ratio code is loaded with a one-cycle strobe. After reset it holds the 16:1 setting.

Top module: `wrr2_sched`

## Requirements
- R1: After synchronous active-high reset, `busy`, `grant_hi` and `grant_lo` are 0 and the stored ratio code is 2'b10. With both queues ready, sixteen urgent grants are then followed by one bulk grant.
- R2: With ratio code 2'b00 and both queues continuously ready, grants repeat the pattern of four urgent frames followed by one bulk frame.
- R3: With ratio code 2'b01 the pattern is eight urgent frames per bulk frame. With code 2'b10 it is sixteen urgent frames per bulk frame.
- R4: With ratio code 2'b11, an idle scheduler grants the urgent queue whenever `hi_ready` is 1, and grants the bulk queue only when `hi_ready` is 0 and `lo_ready` is 1.
- R5: When only one queue is ready and the scheduler is idle, that queue is granted in the next cycle, under every ratio code.
- R6: The urgent-service count returns to zero whenever a bulk frame is granted. In a weighted mode, urgent grants given while the bulk queue is empty raise the count only up to the ratio limit. The next decision with both queues ready then goes to the bulk queue.
- R7: A `cfg_load` strobe stores `cfg_code` at the clock edge. If the new code differs from the stored one, the urgent-service count is cleared. Reloading the same code leaves the count unchanged.
- R8: Once a grant has been issued, `busy` stays 1 and no further grant appears until a `frame_done` pulse is seen. Ready flags held high meanwhile have no effect.
- R9: A decision made from the inputs at one clock edge shows as a grant pulse in the cycle after that edge. `busy` falls in the cycle after `frame_done`. A `frame_done` pulse while idle has no effect.
- R10: Each grant lasts one cycle, and `grant_hi` and `grant_lo` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Strobe: store `cfg_code` as the ratio code |
| cfg_code | input | 2 | Ratio code: 00 = 4:1, 01 = 8:1, 10 = 16:1, 11 = strict urgent-first |
| hi_ready | input | 1 | Urgent queue holds a frame |
| lo_ready | input | 1 | Bulk queue holds a frame |
| frame_done | input | 1 | Pulse: the granted frame has finished |
| grant_hi | output | 1 | One-cycle grant to the urgent queue |
| grant_lo | output | 1 | One-cycle grant to the bulk queue |
| busy | output | 1 | A granted frame is still in progress |

## Verification
A grant and the rise of `busy` are due one cycle after the edge at which the idle scheduler sees a ready flag. The fall of `busy` is due one cycle after the edge that samples `frame_done`. A new ratio code governs the first decision taken at an edge after its load strobe. The bench drives inputs on falling edges and samples on the next falling edge, so every check lands exactly one register stage after its stimulus. A frame-level arithmetic model of the service count supplies the expected grant for every frame, across all four codes and every pair of ready flags.

// File: rtl/wrr2_pkg.sv
package wrr2_pkg;

    // Ratio codes; the encoding is the configuration interface
    typedef enum logic [1:0] {
        RATIO_4   = 2'b00,
        RATIO_8   = 2'b01,
        RATIO_16  = 2'b10,
        STRICT_HI = 2'b11
    } ratio_e;

    localparam ratio_e RESET_RATIO = RATIO_16;
    localparam int     BASE_WEIGHT = 4;
    localparam int     MAX_WEIGHT  = BASE_WEIGHT * 4;
    localparam int     CNT_W       = $clog2(MAX_WEIGHT + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } pick_t;

    // Urgent frames allowed per bulk frame; zero for strict mode
    function automatic cnt_t weight_of(input ratio_e r);
        case (r)
            RATIO_4:  weight_of = cnt_t'(BASE_WEIGHT);
            RATIO_8:  weight_of = cnt_t'(BASE_WEIGHT * 2);
            RATIO_16: weight_of = cnt_t'(BASE_WEIGHT * 4);
            default:  weight_of = '0;
        endcase
    endfunction

endpackage

// File: rtl/wrr2_cfg.sv
module wrr2_cfg
    import wrr2_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_load,
    input  logic [1:0] cfg_code,
    output ratio_e     ratio,
    output logic       changed
);
    ratio_e ratio_q;

    assign changed = cfg_load && (cfg_code != ratio_q);
    assign ratio   = ratio_q;

    always_ff @(posedge clk) begin
        if (rst)
            ratio_q <= RESET_RATIO;
        else if (cfg_load)
            ratio_q <= ratio_e'(cfg_code);
    end
endmodule

// File: rtl/wrr2_pick.sv
module wrr2_pick
    import wrr2_pkg::*;
(
    input  ratio_e ratio,
    input  cnt_t   cnt,
    input  logic   hi_ready,
    input  logic   lo_ready,
    output pick_t  pick
);
    always_comb begin
        pick = '0;
        if (ratio == STRICT_HI) begin
            pick.hi = hi_ready;
            pick.lo = !hi_ready && lo_ready;
        end else if (hi_ready && lo_ready) begin
            pick.hi = (cnt < weight_of(ratio));
            pick.lo = !(cnt < weight_of(ratio));
        end else begin
            pick.hi = hi_ready;
            pick.lo = lo_ready;
        end
    end
endmodule

// File: rtl/wrr2_credit.sv
module wrr2_credit
    import wrr2_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clear,
    input  ratio_e ratio,
    input  logic   take_hi,
    input  logic   take_lo,
    output cnt_t   cnt
);
    cnt_t cnt_q;

    assign cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (take_lo)
            cnt_q <= '0;
        else if (take_hi && ratio != STRICT_HI && cnt_q < weight_of(ratio))
            cnt_q <= cnt_q + cnt_t'(1);
    end
endmodule

// File: rtl/wrr2_sched.sv
module wrr2_sched
    import wrr2_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_load,
    input  logic [1:0] cfg_code,
    input  logic       hi_ready,
    input  logic       lo_ready,
    input  logic       frame_done,
    output logic       grant_hi,
    output logic       grant_lo,
    output logic       busy
);
    ratio_e ratio_q;
    logic   code_changed;
    cnt_t   credit_cnt;
    pick_t  pick;
    logic   decide;
    logic   busy_q;
    pick_t  grant_q;

    wrr2_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_load (cfg_load),
        .cfg_code (cfg_code),
        .ratio    (ratio_q),
        .changed  (code_changed)
    );

    wrr2_pick u_pick (
        .ratio    (ratio_q),
        .cnt      (credit_cnt),
        .hi_ready (hi_ready),
        .lo_ready (lo_ready),
        .pick     (pick)
    );

    assign decide = !busy_q && (hi_ready || lo_ready);

    wrr2_credit u_credit (
        .clk     (clk),
        .rst     (rst),
        .clear   (code_changed),
        .ratio   (ratio_q),
        .take_hi (decide && pick.hi),
        .take_lo (decide && pick.lo),
        .cnt     (credit_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            grant_q <= '0;
        end else begin
            grant_q.hi <= decide && pick.hi;
            grant_q.lo <= decide && pick.lo;
            if (decide)
                busy_q <= 1'b1;
            else if (frame_done)
                busy_q <= 1'b0;
        end
    end

    assign grant_hi = grant_q.hi;
    assign grant_lo = grant_q.lo;
    assign busy     = busy_q;
endmodule

// File: rtl/wrr2_sched_chk.sv
module wrr2_sched_chk
    import wrr2_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   hi_ready,
    input logic   lo_ready,
    input logic   frame_done,
    input logic   grant_hi,
    input logic   grant_lo,
    input logic   busy,
    input ratio_e ratio,
    input cnt_t   cnt
);
    assert_grant_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({grant_hi, grant_lo}));

    assert_grant_single_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        (grant_hi || grant_lo) |=> !(grant_hi || grant_lo));

    assert_grant_with_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (grant_hi || grant_lo) |-> busy);

    assert_hold_until_done_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !frame_done) |=> (busy && !grant_hi && !grant_lo));

    assert_work_conserve_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && (hi_ready || lo_ready)) |=> (grant_hi || grant_lo));

    assert_bulk_alone_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && lo_ready && !hi_ready) |=> grant_lo);

    assert_strict_first_R4: assert property (@(posedge clk) disable iff (rst)
        (!busy && ratio == STRICT_HI && hi_ready) |=> grant_hi);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !hi_ready && !lo_ready) |=> (!busy && !grant_hi && !grant_lo));

    assert_bulk_clears_count_R6: assert property (@(posedge clk) disable iff (rst)
        grant_lo |-> (cnt == '0));

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt <= weight_of(ratio));
endmodule

bind wrr2_sched wrr2_sched_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hi_ready   (hi_ready),
    .lo_ready   (lo_ready),
    .frame_done (frame_done),
    .grant_hi   (grant_hi),
    .grant_lo   (grant_lo),
    .busy       (busy),
    .ratio      (ratio_q),
    .cnt        (credit_cnt)
);

// File: tb/wrr2_sched_tb.sv
module wrr2_sched_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_load = 1'b0;
    logic [1:0] cfg_code = 2'b00;
    logic       hi_ready = 1'b0;
    logic       lo_ready = 1'b0;
    logic       frame_done = 1'b0;
    logic       grant_hi, grant_lo, busy;

    int checks = 0;
    int fails  = 0;
    int mcnt   = 0;
    int mcode  = 2;

    always #2 clk = ~clk;

    wrr2_sched dut_i (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_code(cfg_code),
        .hi_ready(hi_ready), .lo_ready(lo_ready), .frame_done(frame_done),
        .grant_hi(grant_hi), .grant_lo(grant_lo), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int wgt(input int c);
        return (c == 3) ? 0 : (4 << c);
    endfunction

    // Expected grant from the frame-level model
    function automatic int expect_pick(input bit h, input bit l);
        if (!h && !l) return 0;
        if (mcode == 3) return h ? 1 : 2;
        if (h && l) return (mcnt < wgt(mcode)) ? 1 : 2;
        return h ? 1 : 2;
    endfunction

    function automatic void model_update(input int g);
        if (g == 2) mcnt = 0;
        else if (g == 1 && mcode != 3 && mcnt < wgt(mcode)) mcnt++;
    endfunction

    function automatic string tag(input bit h, input bit l);
        if (h != l) return "R5";
        if (!h) return "R9";
        case (mcode)
            0: return "R2";
            3: return "R4";
            default: return "R3";
        endcase
    endfunction

    // Called at a falling edge; returns at a falling edge, idle
    task automatic frame(input bit h, input bit l, output int got);
        int e;
        string t;
        e = expect_pick(h, l);
        t = tag(h, l);
        hi_ready = h;
        lo_ready = l;
        @(negedge clk);
        got = grant_hi ? 1 : (grant_lo ? 2 : 0);
        check(t, got, e);
        check("R8", busy, (h || l) ? 1 : 0);
        check("R10", grant_hi && grant_lo, 0);
        model_update(e);
        hi_ready = 1'b0;
        lo_ready = 1'b0;
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        check("R9", busy, 0);
        check("R10", grant_hi || grant_lo, 0);
    endtask

    task automatic load(input int c);
        cfg_code = 2'(c);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        if (c != mcode) mcnt = 0;
        mcode = c;
    endtask

    // Both queues ready until the bulk queue is served; returns urgent count
    task automatic run_to_bulk(output int n);
        int g;
        n = 0;
        for (int i = 0; i < 40; i++) begin
            frame(1'b1, 1'b1, g);
            if (g == 2) break;
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n, g;
        logic [7:0] lfsr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", busy, 0);
        check("R1", grant_hi || grant_lo, 0);
        @(negedge clk);
        check("R1", busy, 0);

        // Reset default is the 16:1 ratio
        run_to_bulk(n);
        check("R1", n, 16);

        // Both-ready patterns for each weighted code, two rounds each
        for (int c = 0; c < 3; c++) begin
            load(c);
            for (int r = 0; r < 2; r++) begin
                run_to_bulk(n);
                check(c == 0 ? "R2" : "R3", n, wgt(c));
            end
        end

        // Strict mode: urgent always wins
        load(3);
        for (int i = 0; i < 20; i++) begin
            frame(1'b1, 1'b1, g);
            check("R4", g, 1);
        end
        frame(1'b0, 1'b1, g);
        check("R4", g, 2);

        // Urgent-only service saturates the count; bulk then goes next
        load(0);
        for (int i = 0; i < 9; i++) frame(1'b1, 1'b0, g);
        frame(1'b1, 1'b1, g);
        check("R6", g, 2);
        run_to_bulk(n);
        check("R6", n, 4);

        // Same code reload keeps the count; a new code clears it
        frame(1'b1, 1'b1, g);
        frame(1'b1, 1'b1, g);
        load(0);
        run_to_bulk(n);
        check("R7", n, 2);
        frame(1'b1, 1'b1, g);
        frame(1'b1, 1'b1, g);
        load(1);
        run_to_bulk(n);
        check("R7", n, 8);

        // Busy hold: no grant until frame_done, ready held high
        hi_ready = 1'b1;
        lo_ready = 1'b1;
        @(negedge clk);
        g = grant_hi ? 1 : (grant_lo ? 2 : 0);
        check("R8", g, expect_pick(1'b1, 1'b1));
        model_update(expect_pick(1'b1, 1'b1));
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R8", grant_hi || grant_lo, 0);
            check("R8", busy, 1);
        end
        hi_ready = 1'b0;
        lo_ready = 1'b0;
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        check("R9", busy, 0);

        // frame_done while idle is ignored
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        check("R9", busy, 0);
        check("R9", grant_hi || grant_lo, 0);

        // Pseudo-random ready patterns under every code
        lfsr = 8'hA5;
        for (int c = 0; c < 4; c++) begin
            load(c);
            for (int i = 0; i < 150; i++) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                frame(lfsr[0] | lfsr[1], lfsr[2] & ~lfsr[3] | lfsr[4] & lfsr[0], g);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule